// File: doc/BRIEF.md
# Video DAC Clock-Synthesizer Register Interface

This block is the register file of a video DAC that has a clock synthesizer built in. A host reaches it through four byte-wide I/O ports, selected by a 2-bit port number. Port 0 is the pixel-mask port, which also leads to the command register. Port 1 is the read index. Port 2 is the write index. Port 3 is the data port. The synthesizer has a bank of frequency entries. Each entry holds an M divider byte and a packed N1/N2 byte, and the host reaches an entry by first loading an index and then making two data-port accesses. Index 0x0E selects a control register instead, which takes one data-port access. The low bits of the control register choose which entry drives the divider outputs.

The command register is hidden behind the mask port. Three reads of the mask port in a row return the mask. The fourth read returns the identification byte 0xB1, and after that the block is armed. While it is armed, mask-port reads return the command register and the next mask-port write goes to the command register. The top three command bits leave the block as the colour-mode code for the pixel path.

Top module: `vdac_pll_regs`

## Requirements
- R1: After reset the following values hold. The pixel mask is 0xFF, the command register is 0x00, both index registers are 0 with their byte pointers on the M byte, and the control register is 0x02. Every entry holds M code 0x3D and N byte 0x2B, so the outputs are pll_m_code=0x3D, pll_n1_code=0x0B, pll_n2=1 and color_mode=0.
- R2: After an index below 8 is written to port 2, the next data-port (port 3) write loads that entry's M byte and the write after it loads the N byte. The pointer then returns to the M byte.
- R3: After an index below 8 is written to port 1, two data-port reads return that entry's M byte and then its N byte. The read pointer is separate from the write index and the write pointer, and neither of those affects it.
- R4: Writing an index register puts its byte pointer back on the M byte, including when the pair was only half completed.
- R5: Index 0x0E selects the control register. A single data-port write stores all 8 bits, a single read returns them, and neither access moves a byte pointer.
- R6: Control bits [2:0] pick the entry that drives the outputs. pll_m_code is the M byte [6:0]. The N byte is packed with N1 minus 2 in bits [4:0] (pll_n1_code) and N2 in bits [6:5] (pll_n2). Bit 7 of the M and N bytes is not stored and reads as 0.
- R7: The first three mask-port reads in a row return the pixel mask, and the fourth returns 0xB1.
- R8: Once the block is armed, a mask-port read returns the command register and a mask-port write loads the command register, which then disarms the block. color_mode is command bits [7:5], with code 0 for 8-bit palette (0x00), 1 for 5-5-5 (0x20), 3 for 5-6-5 (0x60) and 2 for 24-bit packed (0x40).
- R9: Any access to port 1, 2 or 3 clears the mask-read run. Any mask-port write made before the block is armed goes to the pixel mask and leaves the command register unchanged.
- R10: When the selected index is neither below 8 nor 0x0E, data-port writes are ignored and data-port reads return 0x00.
- R11: Every read access puts its data on rdata, and rd_valid goes high for exactly the following cycle. rdata keeps its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_valid | input | 1 | An access happens in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_port | input | 2 | Port number: 0 mask, 1 read index, 2 write index, 3 data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Data from the last read access |
| rd_valid | output | 1 | rdata was updated by the read in the previous cycle |
| pll_m_code | output | 7 | M code of the entry picked by the control register |
| pll_n1_code | output | 5 | N1 code (N1 minus 2) of the picked entry |
| pll_n2 | output | 2 | N2 post-divider exponent of the picked entry |
| color_mode | output | 3 | Colour-mode code, command bits [7:5] |
| pix_mask | output | 8 | Pixel mask register |

## Verification
The hardest state to reach from the ports is the armed state at the exact moment of a mask-port write. The state depends on an unbroken run of four mask reads, and an access to any other port in the middle of the run has to reset it. The bench builds runs of different lengths, breaks some of them with an index write, and then follows each with a mask write. It then reads back through the mask port and watches color_mode to see which register took the byte. A checker keeps its own count of the run and follows the same sequences cycle by cycle.

// File: rtl/vdac_pkg.sv
package vdac_pkg;
  typedef enum logic [1:0] {
    PORT_MASK = 2'd0,
    PORT_RIDX = 2'd1,
    PORT_WIDX = 2'd2,
    PORT_DATA = 2'd3
  } port_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CODE_W = 7;
endpackage

// File: rtl/vdac_hidden_seq.sv
module vdac_hidden_seq #(
  parameter int unsigned RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_rd,
  input  logic mask_wr,
  input  logic other_acc,
  output logic id_turn,
  output logic armed
);
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] ID_AT = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (other_acc || mask_wr) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (mask_rd && (cnt_q != LIMIT)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign id_turn = (cnt_q == ID_AT);
  assign armed   = (cnt_q == LIMIT);
endmodule

// File: rtl/vdac_index_ptr.sv
module vdac_index_ptr #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] index,
  output logic             hi_byte
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             sel_q, sel_d;
  logic             en;

  always_comb begin
    en    = load | step;
    idx_d = idx_q;
    sel_d = sel_q;
    if (load) begin
      idx_d = load_val;
      sel_d = 1'b0;
    end else if (step) begin
      sel_d = ~sel_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      sel_q <= 1'b0;
    end else if (en) begin
      idx_q <= idx_d;
      sel_q <= sel_d;
    end
  end

  assign index   = idx_q;
  assign hi_byte = sel_q;
endmodule

// File: rtl/vdac_pll_bank.sv
module vdac_pll_bank #(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned CODE_W      = 7,
  parameter logic [CODE_W-1:0] DEF_M = 7'h3D,
  parameter logic [CODE_W-1:0] DEF_N = 7'h2B,
  localparam int unsigned SEL_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_idx,
  input  logic              wr_hi,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_idx,
  output logic [CODE_W-1:0] rd_m,
  output logic [CODE_W-1:0] rd_n,
  input  logic [SEL_W-1:0]  act_idx,
  output logic [CODE_W-1:0] act_m,
  output logic [CODE_W-1:0] act_n
);
  logic [CODE_W-1:0] m_q [NUM_ENTRIES];
  logic [CODE_W-1:0] n_q [NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic hit, m_en, n_en;
    always_comb begin
      hit  = wr_en && (wr_idx == SEL_W'(e));
      m_en = hit && !wr_hi;
      n_en = hit &&  wr_hi;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    m_q[e] <= DEF_M;
      else if (m_en) m_q[e] <= wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    n_q[e] <= DEF_N;
      else if (n_en) n_q[e] <= wr_data;
    end
  end

  assign rd_m  = m_q[rd_idx];
  assign rd_n  = n_q[rd_idx];
  assign act_m = m_q[act_idx];
  assign act_n = n_q[act_idx];
endmodule

// File: rtl/vdac_pll_regs.sv
module vdac_pll_regs #(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned RUN_LEN     = 4,
  parameter logic [7:0]  CTRL_INDEX  = 8'h0E,
  parameter logic [7:0]  ID_VALUE    = 8'hB1,
  parameter logic [7:0]  CTRL_RESET  = 8'h02,
  parameter logic [7:0]  MASK_RESET  = 8'hFF,
  parameter logic [6:0]  DEF_M       = 7'h3D,
  parameter logic [6:0]  DEF_N       = 7'h2B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic [1:0] acc_port,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rd_valid,
  output logic [6:0] pll_m_code,
  output logic [4:0] pll_n1_code,
  output logic [1:0] pll_n2,
  output logic [2:0] color_mode,
  output logic [7:0] pix_mask
);
  import vdac_pkg::*;

  localparam int unsigned SEL_W = $clog2(NUM_ENTRIES);
  localparam logic [7:0]  ENTRY_LIM = 8'(NUM_ENTRIES);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // access decode
  port_e port;
  logic  acc_rd, acc_wr;
  logic  mask_rd, mask_wr, other_acc;
  logic  ridx_wr, widx_wr, data_rd, data_wr;

  always_comb begin
    port      = port_e'(acc_port);
    acc_rd    = acc_valid && !acc_write;
    acc_wr    = acc_valid &&  acc_write;
    mask_rd   = acc_rd && (port == PORT_MASK);
    mask_wr   = acc_wr && (port == PORT_MASK);
    other_acc = acc_valid && (port != PORT_MASK);
    ridx_wr   = acc_wr && (port == PORT_RIDX);
    widx_wr   = acc_wr && (port == PORT_WIDX);
    data_rd   = acc_rd && (port == PORT_DATA);
    data_wr   = acc_wr && (port == PORT_DATA);
  end

  // hidden command access
  logic id_turn, armed;
  vdac_hidden_seq #(.RUN_LEN(RUN_LEN)) u_hidden (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mask_rd   (mask_rd),
    .mask_wr   (mask_wr),
    .other_acc (other_acc),
    .id_turn   (id_turn),
    .armed     (armed)
  );

  // index pointers
  logic [7:0] widx, ridx;
  logic       wsel, rsel;
  logic       w_entry, r_entry, w_ctrl, r_ctrl;
  logic       w_step, r_step;

  always_comb begin
    w_entry = (widx < ENTRY_LIM);
    r_entry = (ridx < ENTRY_LIM);
    w_ctrl  = (widx == CTRL_INDEX);
    r_ctrl  = (ridx == CTRL_INDEX);
    w_step  = data_wr && w_entry;
    r_step  = data_rd && r_entry;
  end

  vdac_index_ptr #(.IDX_W(8)) u_wptr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (widx_wr),
    .load_val (wdata),
    .step     (w_step),
    .index    (widx),
    .hi_byte  (wsel)
  );

  vdac_index_ptr #(.IDX_W(8)) u_rptr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (ridx_wr),
    .load_val (wdata),
    .step     (r_step),
    .index    (ridx),
    .hi_byte  (rsel)
  );

  // control, command and mask registers
  logic [7:0] ctrl_q, cmd_q, mask_q;
  logic       ctrl_en, cmd_en, mask_en;

  always_comb begin
    ctrl_en = data_wr && w_ctrl;
    cmd_en  = mask_wr && armed;
    mask_en = mask_wr && !armed;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   ctrl_q <= CTRL_RESET;
    else if (ctrl_en) ctrl_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  cmd_q <= 8'h00;
    else if (cmd_en) cmd_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   mask_q <= MASK_RESET;
    else if (mask_en) mask_q <= wdata;
  end

  // divider bank
  logic [6:0] rd_m, rd_n, act_m, act_n;
  vdac_pll_bank #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .CODE_W      (7),
    .DEF_M       (DEF_M),
    .DEF_N       (DEF_N)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (w_step),
    .wr_idx  (widx[SEL_W-1:0]),
    .wr_hi   (wsel),
    .wr_data (wdata[6:0]),
    .rd_idx  (ridx[SEL_W-1:0]),
    .rd_m    (rd_m),
    .rd_n    (rd_n),
    .act_idx (ctrl_q[SEL_W-1:0]),
    .act_m   (act_m),
    .act_n   (act_n)
  );

  // read path
  logic [7:0] rd_mux, rdata_q;
  logic       rdv_q;

  always_comb begin
    rd_mux = 8'h00;
    unique case (port)
      PORT_MASK: rd_mux = id_turn ? ID_VALUE : (armed ? cmd_q : mask_q);
      PORT_RIDX: rd_mux = ridx;
      PORT_WIDX: rd_mux = widx;
      PORT_DATA: begin
        if (r_ctrl)       rd_mux = ctrl_q;
        else if (r_entry) rd_mux = rsel ? {1'b0, rd_n} : {1'b0, rd_m};
        else              rd_mux = 8'h00;
      end
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= 8'h00;
    else if (acc_rd) rdata_q <= rd_mux;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdv_q <= 1'b0;
    else            rdv_q <= acc_rd;
  end

  assign rdata       = rdata_q;
  assign rd_valid    = rdv_q;
  assign pll_m_code  = act_m;
  assign pll_n1_code = act_n[4:0];
  assign pll_n2      = act_n[6:5];
  assign color_mode  = cmd_q[7:5];
  assign pix_mask    = mask_q;
endmodule

// File: rtl/vdac_pll_regs_chk.sv
module vdac_pll_regs_chk #(
  parameter int unsigned RUN_LEN  = 4,
  parameter logic [7:0]  ID_VALUE = 8'hB1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic       acc_write,
  input logic [1:0] acc_port,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       rd_valid,
  input logic [6:0] pll_m_code,
  input logic [4:0] pll_n1_code,
  input logic [1:0] pll_n2,
  input logic [2:0] color_mode,
  input logic [7:0] pix_mask
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LIM = CW'(RUN_LEN);
  localparam logic [CW-1:0] IDP = CW'(RUN_LEN - 1);

  logic          live;
  logic [CW-1:0] run_q;
  logic          m_rd, m_wr, d_wr, any_rd;

  assign m_rd   = acc_valid && !acc_write && (acc_port == 2'd0);
  assign m_wr   = acc_valid &&  acc_write && (acc_port == 2'd0);
  assign d_wr   = acc_valid &&  acc_write && (acc_port == 2'd3);
  assign any_rd = acc_valid && !acc_write;

  // own view of the mask-read run, counted only while the block is out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live  <= 1'b0;
      run_q <= '0;
    end else begin
      live <= 1'b1;
      if (acc_valid && (acc_port != 2'd0)) run_q <= '0;
      else if (m_wr)                       run_q <= '0;
      else if (m_rd && run_q != LIM)       run_q <= run_q + 1'b1;
    end
  end

  // R11
  rd_valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && any_rd |=> rd_valid);

  // R11
  rd_valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && !any_rd |=> !rd_valid);

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && !any_rd |=> $stable(rdata));

  // R7
  id_on_fourth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && m_rd && (run_q == IDP) |=> rdata == ID_VALUE);

  // R8
  cmd_takes_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && m_wr && (run_q == LIM) |=> color_mode == $past(wdata[7:5]));

  // R9
  early_write_to_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && m_wr && (run_q != LIM) |=> $stable(color_mode) && pix_mask == $past(wdata));

  // R6
  dividers_need_data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && !d_wr |=> $stable(pll_m_code) && $stable(pll_n1_code) && $stable(pll_n2));
endmodule

bind vdac_pll_regs vdac_pll_regs_chk #(
  .RUN_LEN  (RUN_LEN),
  .ID_VALUE (ID_VALUE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .acc_port    (acc_port),
  .wdata       (wdata),
  .rdata       (rdata),
  .rd_valid    (rd_valid),
  .pll_m_code  (pll_m_code),
  .pll_n1_code (pll_n1_code),
  .pll_n2      (pll_n2),
  .color_mode  (color_mode),
  .pix_mask    (pix_mask)
);

// File: tb/sim_vdac_pll_regs.sv
`timescale 1ns/1ps
module sim_vdac_pll_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_valid, acc_write;
  logic [1:0] acc_port;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       rd_valid;
  logic [6:0] pll_m_code;
  logic [4:0] pll_n1_code;
  logic [1:0] pll_n2;
  logic [2:0] color_mode;
  logic [7:0] pix_mask;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  vdac_pll_regs u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_port    (acc_port),
    .wdata       (wdata),
    .rdata       (rdata),
    .rd_valid    (rd_valid),
    .pll_m_code  (pll_m_code),
    .pll_n1_code (pll_n1_code),
    .pll_n2      (pll_n2),
    .color_mode  (color_mode),
    .pix_mask    (pix_mask)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // each access starts and ends at a falling edge
  task automatic wr(input logic [1:0] p, input logic [7:0] d);
    acc_valid = 1'b1; acc_write = 1'b1; acc_port = p; wdata = d;
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] p, output logic [7:0] d, output logic v);
    acc_valid = 1'b1; acc_write = 1'b0; acc_port = p; wdata = 8'h00;
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0;
    d = rdata; v = rd_valid;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] p, input logic [7:0] exp);
    logic [7:0] d; logic v;
    rd(p, d, v);
    chk(tag, int'(d), int'(exp));
  endtask

  task automatic t_reset;
    logic [7:0] d; logic v;
    chk("R1 m code", pll_m_code, 7'h3D);
    chk("R1 n1 code", pll_n1_code, 5'h0B);
    chk("R1 n2", pll_n2, 1);
    chk("R1 color", color_mode, 0);
    chk("R1 mask", pix_mask, 8'hFF);
    chk("R1 rd_valid idle", rd_valid, 0);
    rd_chk("R1 ridx", 2'd1, 8'h00);
    rd_chk("R1 widx", 2'd2, 8'h00);
    rd(2'd3, d, v);
    chk("R1 entry0 M", d, 8'h3D);
    chk("R11 rd_valid after read", v, 1);
    @(negedge clk);
    chk("R11 rd_valid one cycle", rd_valid, 0);
    chk("R11 rdata held", rdata, 8'h3D);
    rd_chk("R1 entry0 N", 2'd3, 8'h2B);
    wr(2'd1, 8'h0E);
    rd_chk("R1 ctrl", 2'd3, 8'h02);
  endtask

  task automatic t_pair_write;
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h55);
    wr(2'd3, 8'hA7);
    chk("R2 out m", pll_m_code, 7'h55);
    chk("R6 out n1", pll_n1_code, 5'h07);
    chk("R6 out n2", pll_n2, 1);
    wr(2'd1, 8'h02);
    rd_chk("R3 M byte", 2'd3, 8'h55);
    rd_chk("R6 N bit7 dropped", 2'd3, 8'h27);
    wr(2'd3, 8'h13);   // write pointer back on M
    rd_chk("R2 pointer wrapped", 2'd3, 8'h13);
  endtask

  task automatic t_pointers;
    wr(2'd2, 8'h05);
    wr(2'd3, 8'h11);
    wr(2'd2, 8'h05);   // half pair abandoned
    wr(2'd3, 8'h22);
    wr(2'd3, 8'h33);
    wr(2'd1, 8'h05);
    rd_chk("R4 M after reload", 2'd3, 8'h22);
    wr(2'd2, 8'h04);
    wr(2'd3, 8'h44);
    rd_chk("R3 read pointer independent", 2'd3, 8'h33);
    wr(2'd1, 8'h05);
    wr(2'd1, 8'h04);
    rd_chk("R4 read reload to M", 2'd3, 8'h44);
  endtask

  task automatic t_control;
    wr(2'd2, 8'h0E);
    wr(2'd3, 8'h05);
    chk("R6 sel entry5 m", pll_m_code, 7'h22);
    chk("R6 sel entry5 n1", pll_n1_code, 5'h13);
    chk("R6 sel entry5 n2", pll_n2, 1);
    wr(2'd1, 8'h0E);
    rd_chk("R5 ctrl read", 2'd3, 8'h05);
    rd_chk("R5 ctrl read again", 2'd3, 8'h05);
    wr(2'd3, 8'h04);
    chk("R5 ctrl single write", pll_m_code, 7'h44);
  endtask

  task automatic t_unmapped;
    wr(2'd2, 8'h20);
    wr(2'd3, 8'h99);
    wr(2'd3, 8'h98);
    chk("R10 outputs kept", pll_m_code, 7'h44);
    wr(2'd1, 8'h20);
    rd_chk("R10 unmapped read", 2'd3, 8'h00);
    wr(2'd1, 8'h00);
    rd_chk("R10 entry0 untouched", 2'd3, 8'h3D);
  endtask

  task automatic arm_and_set(input string tag, input logic [7:0] cmd, input int code);
    wr(2'd1, 8'h00);
    rd_chk({tag, " R7 read1"}, 2'd0, pix_mask);
    rd_chk({tag, " R7 read2"}, 2'd0, pix_mask);
    rd_chk({tag, " R7 read3"}, 2'd0, pix_mask);
    rd_chk({tag, " R7 id"}, 2'd0, 8'hB1);
    wr(2'd0, cmd);
    chk({tag, " R8 color"}, color_mode, code);
    chk({tag, " R8 mask kept"}, pix_mask, 8'hFF);
  endtask

  task automatic t_hidden;
    arm_and_set("555", 8'h20, 1);
    arm_and_set("565", 8'h60, 3);
    wr(2'd1, 8'h00);
    repeat (3) rd_chk("R7 run", 2'd0, 8'hFF);
    rd_chk("R7 id", 2'd0, 8'hB1);
    rd_chk("R8 armed read cmd", 2'd0, 8'h60);
    rd_chk("R8 armed read stays", 2'd0, 8'h60);
    wr(2'd0, 8'h40);
    chk("R8 888 code", color_mode, 2);
    rd_chk("R8 disarmed after write", 2'd0, 8'hFF);
    arm_and_set("pal", 8'h00, 0);
  endtask

  task automatic t_clear;
    wr(2'd1, 8'h00);
    rd_chk("R9 r1", 2'd0, 8'hFF);
    rd_chk("R9 r2", 2'd0, 8'hFF);
    rd_chk("R9 r3", 2'd0, 8'hFF);
    wr(2'd2, 8'h00);   // breaks the run
    rd_chk("R9 no id after break", 2'd0, 8'hFF);
    rd_chk("R9 r2b", 2'd0, 8'hFF);
    rd_chk("R9 r3b", 2'd0, 8'hFF);
    wr(2'd0, 8'h0F);   // not armed: goes to mask
    chk("R9 mask written", pix_mask, 8'h0F);
    chk("R9 cmd kept", color_mode, 0);
    rd_chk("R9 mask readback", 2'd0, 8'h0F);
    wr(2'd0, 8'hFF);
  endtask

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_port = 2'd0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pair_write();
    t_pointers();
    t_control();
    t_unmapped();
    t_hidden();
    t_clear();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule